// File: doc/BRIEF.md
# Configuration Variable Access Unit

This block executes configuration-variable access instructions for a mobile decoder. It keeps a small file of byte-wide configuration values. It reads and writes that file on command from packets that an upstream parser has already framed, checked and matched against the decoder's addresses. Each packet arrives as a one-cycle strobe. The strobe comes with up to three instruction bytes and three flags. The flags say whether the packet went to this decoder's own address, to the broadcast address or to its consist address. A packet with no flag set belongs to some other decoder.

The long form carries a 10-bit variable address. The variable number is that address plus one. It carries one of three operations: verify a byte, write a byte, or verify or write a single bit. Writes are guarded. The first write packet is only held as pending. The file changes when a second packet with the same bytes arrives at the decoder's own address. Any other packet to this decoder in between, a broadcast included, throws the pending write away. The short form changes the acceleration or deceleration value with a single packet. A verify that matches raises a one-cycle response pulse. A committed write raises a one-cycle acknowledge pulse. A write to a location inside the file also raises a write strobe with its address and data.

Top module: `cv_access_unit`

## Requirements
- R1: After reset, every output is low and every location of the file holds 0x00.
- R2: A long-form byte write uses byte0 = 1110_11AA, byte1 = low 8 address bits and byte2 = data. The first packet produces no output. A second identical packet to the own address commits the write, and one cycle after it cv_wr_en, cv_wr_addr, cv_wr_data and write_ack show the write for exactly one cycle.
- R3: A pending write is discarded when any packet flagged own, broadcast or consist arrives and differs from the pending one, or is not itself an executable repeat. The next matching write packet then counts as a new first packet.
- R4: A packet with none of the three flags set leaves a pending write intact and produces no output.
- R5: A long-form byte verify uses byte0 = 1110_01AA. It pulses verify_ok one cycle later exactly when the stored byte equals byte2.
- R6: A long-form bit operation uses byte0 = 1110_10AA and byte2 = 111C_DPPP. PPP is the bit position and D is the bit value. C = 1 writes the bit, under the same two-packet rule as R2, and leaves the other seven bits unchanged. C = 0 pulses verify_ok when the stored bit equals D.
- R7: Long-form code 00 is ignored. A bit operation whose byte2 does not start with 111 is ignored. Neither produces any output.
- R8: A long-form packet flagged consist has no effect other than the discard of R3.
- R9: The short form is byte0 = 1111_CCCC with data in byte1. It acts at the own or the consist address. Code 0010 writes address 22 and code 0011 writes address 23, and each commits on one packet with a strobe and an acknowledge. Every other code produces no output.
- R10: Addresses at or above DEPTH read as 0x00. A committed write to such an address pulses write_ack but never cv_wr_en.
- R11: A broadcast packet never verifies, writes or acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One-cycle strobe for a received packet |
| pkt_byte0 | input | 8 | First instruction byte |
| pkt_byte1 | input | 8 | Second instruction byte |
| pkt_byte2 | input | 8 | Third instruction byte (long form only) |
| addr_match | input | 1 | Packet was sent to the decoder's own address |
| addr_bcast | input | 1 | Packet was sent to the broadcast address |
| addr_consist | input | 1 | Packet was sent to the decoder's consist address |
| cv_wr_en | output | 1 | Write strobe into the value file |
| cv_wr_addr | output | 10 | Address written (variable number minus one) |
| cv_wr_data | output | 8 | Byte written |
| verify_ok | output | 1 | Pulse on a matching verify |
| write_ack | output | 1 | Pulse on a committed write |

## Verification
The checker assumes the parser raises at most one of the three address flags with each strobe. The bench always drives a single flag or none. The checker also assumes the instruction bytes only matter while pkt_valid is high. The bench lowers the strobe and leaves at least one idle cycle after each packet, so each pulse is seen alone. Bit-level expectations are worked out from byte values the bench itself wrote earlier, never from state read out of the design.

// File: rtl/cv_access_pkg.sv
package cv_access_pkg;

    localparam int CV_AW = 10;

    localparam logic [CV_AW-1:0] ACCEL_ADDR = 10'd22;
    localparam logic [CV_AW-1:0] DECEL_ADDR = 10'd23;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_VFY_BYTE,
        OP_WR_BYTE,
        OP_VFY_BIT,
        OP_WR_BIT,
        OP_QUICK_WR
    } cv_op_e;

    typedef struct packed {
        cv_op_e           op;
        logic [CV_AW-1:0] addr;
        logic [7:0]       data;
        logic [2:0]       bpos;
        logic             bval;
    } cv_cmd_t;

endpackage

// File: rtl/cv_access_decode.sv
module cv_access_decode
    import cv_access_pkg::*;
(
    input  logic [7:0] ins0,
    input  logic [7:0] ins1,
    input  logic [7:0] ins2,
    output cv_cmd_t    cmd
);

    always_comb begin
        cmd      = '0;
        cmd.op   = OP_NONE;
        cmd.addr = {ins0[1:0], ins1};
        cmd.data = ins2;
        cmd.bpos = ins2[2:0];
        cmd.bval = ins2[3];
        if (ins0[7:4] == 4'b1110) begin
            unique case (ins0[3:2])
                2'b01: cmd.op = OP_VFY_BYTE;
                2'b11: cmd.op = OP_WR_BYTE;
                2'b10: begin
                    if (ins2[7:5] == 3'b111)
                        cmd.op = ins2[4] ? OP_WR_BIT : OP_VFY_BIT;
                end
                default: cmd.op = OP_NONE;
            endcase
        end else if (ins0[7:4] == 4'b1111) begin
            cmd.data = ins1;
            if (ins0[3:0] == 4'b0010) begin
                cmd.op   = OP_QUICK_WR;
                cmd.addr = ACCEL_ADDR;
            end else if (ins0[3:0] == 4'b0011) begin
                cmd.op   = OP_QUICK_WR;
                cmd.addr = DECEL_ADDR;
            end
        end
    end

endmodule

// File: rtl/cv_access_store.sv
module cv_access_store
    import cv_access_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CV_AW-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic             we,
    input  logic [CV_AW-1:0] wr_addr,
    input  logic [7:0]       wr_data
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem_q [DEPTH];

    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_addr) < DEPTH)
            rd_data = mem_q[rd_addr[IW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= 8'h00;
        end else if (we && (int'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr[IW-1:0]] <= wr_data;
        end
    end

endmodule

// File: rtl/cv_access_unit.sv
module cv_access_unit
    import cv_access_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [7:0]       pkt_byte0,
    input  logic [7:0]       pkt_byte1,
    input  logic [7:0]       pkt_byte2,
    input  logic             addr_match,
    input  logic             addr_bcast,
    input  logic             addr_consist,
    output logic             cv_wr_en,
    output logic [CV_AW-1:0] cv_wr_addr,
    output logic [7:0]       cv_wr_data,
    output logic             verify_ok,
    output logic             write_ack
);

    typedef struct packed {
        logic             pend_vld;
        logic [23:0]      pend_pkt;
        logic             wr_en;
        logic [CV_AW-1:0] wr_addr;
        logic [7:0]       wr_data;
        logic             vfy;
        logic             ack;
    } state_t;

    state_t     st_d, st_q;
    cv_cmd_t    cmd;
    logic [7:0] rd_byte;
    logic       to_us, run, same, commit, in_range;
    logic [7:0] bit_merged;

    cv_access_decode u_dec (
        .ins0 (pkt_byte0),
        .ins1 (pkt_byte1),
        .ins2 (pkt_byte2),
        .cmd  (cmd)
    );

    cv_access_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (cmd.addr),
        .rd_data (rd_byte),
        .we      (st_d.wr_en),
        .wr_addr (st_d.wr_addr),
        .wr_data (st_d.wr_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.vfy   = 1'b0;
        st_d.ack   = 1'b0;
        commit     = 1'b0;

        to_us    = pkt_valid && (addr_match || addr_bcast || addr_consist);
        run      = pkt_valid && !addr_bcast &&
                   (addr_match || (addr_consist && cmd.op == OP_QUICK_WR));
        same     = st_q.pend_vld &&
                   (st_q.pend_pkt == {pkt_byte0, pkt_byte1, pkt_byte2});
        in_range = int'(cmd.addr) < DEPTH;

        bit_merged           = rd_byte;
        bit_merged[cmd.bpos] = cmd.bval;

        if (to_us)
            st_d.pend_vld = 1'b0;

        if (run) begin
            unique case (cmd.op)
                OP_VFY_BYTE: st_d.vfy = (rd_byte == cmd.data);
                OP_VFY_BIT:  st_d.vfy = (rd_byte[cmd.bpos] == cmd.bval);
                OP_WR_BYTE, OP_WR_BIT: begin
                    if (same) begin
                        commit = 1'b1;
                    end else begin
                        st_d.pend_vld = 1'b1;
                        st_d.pend_pkt = {pkt_byte0, pkt_byte1, pkt_byte2};
                    end
                end
                OP_QUICK_WR: commit = 1'b1;
                default: ;
            endcase
        end

        if (commit) begin
            st_d.ack     = 1'b1;
            st_d.wr_en   = in_range;
            st_d.wr_addr = cmd.addr;
            st_d.wr_data = (cmd.op == OP_WR_BIT) ? bit_merged : cmd.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cv_wr_en   = st_q.wr_en;
    assign cv_wr_addr = st_q.wr_addr;
    assign cv_wr_data = st_q.wr_data;
    assign verify_ok  = st_q.vfy;
    assign write_ack  = st_q.ack;

endmodule

// File: rtl/cv_access_chk.sv
module cv_access_chk
    import cv_access_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [7:0]       pkt_byte0,
    input logic [7:0]       pkt_byte1,
    input logic [7:0]       pkt_byte2,
    input logic             addr_match,
    input logic             addr_bcast,
    input logic             addr_consist,
    input logic             cv_wr_en,
    input logic [CV_AW-1:0] cv_wr_addr,
    input logic [7:0]       cv_wr_data,
    input logic             verify_ok,
    input logic             write_ack
);

    logic unused_ok;
    assign unused_ok = ^{pkt_byte1, pkt_byte2, cv_wr_data};

    // R3: at most one address class per packet (input assumption)
    a_r3_flags_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $onehot0({addr_match, addr_bcast, addr_consist}));

    // R1: no pulse without a packet in the cycle before
    a_r1_pulse_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !(cv_wr_en || verify_ok || write_ack));

    // R2: every write strobe belongs to an acknowledged commit
    a_r2_strobe_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr_en |-> write_ack);

    // R5: verify and commit never share a packet
    a_r5_vfy_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(verify_ok && write_ack));

    // R7: reserved long-form code stays silent
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_byte0[7:2] == 6'b111000) |=>
            !(cv_wr_en || verify_ok || write_ack));

    // R8: long form at the consist address stays silent
    a_r8_consist_long_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && addr_consist && pkt_byte0[7:4] == 4'b1110) |=>
            !(cv_wr_en || verify_ok || write_ack));

    // R10: strobes only reach locations inside the file
    a_r10_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr_en |-> (int'(cv_wr_addr) < DEPTH));

    // R11: broadcast never acts
    a_r11_bcast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && addr_bcast) |=> !(cv_wr_en || verify_ok || write_ack));

endmodule

bind cv_access_unit cv_access_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/cv_access_unit_tb.sv
module cv_access_unit_tb;

    localparam int DEPTH = 32;
    localparam logic [2:0] ME = 3'b001, BC = 3'b010, CO = 3'b100, NONE = 3'b000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [7:0] b0 = '0, b1 = '0, b2 = '0;
    logic       f_me = 1'b0, f_bc = 1'b0, f_co = 1'b0;
    logic       wr_en, vfy, ack;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       g_wr, g_vfy, g_ack;
    logic [9:0] g_addr;
    logic [7:0] g_data;

    always #5 clk = ~clk;

    cv_access_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .pkt_byte0(b0), .pkt_byte1(b1), .pkt_byte2(b2),
        .addr_match(f_me), .addr_bcast(f_bc), .addr_consist(f_co),
        .cv_wr_en(wr_en), .cv_wr_addr(wr_addr), .cv_wr_data(wr_data),
        .verify_ok(vfy), .write_ack(ack)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] x0, x1, x2, input logic [2:0] fl);
        @(negedge clk);
        pkt_valid = 1'b1; b0 = x0; b1 = x1; b2 = x2;
        {f_co, f_bc, f_me} = fl;
        @(negedge clk);
        pkt_valid = 1'b0; {f_co, f_bc, f_me} = 3'b000;
        g_wr = wr_en; g_vfy = vfy; g_ack = ack; g_addr = wr_addr; g_data = wr_data;
        @(negedge clk);
    endtask

    task automatic expect_quiet(input string tag);
        chk(tag, {g_wr, g_vfy, g_ack}, 0);
    endtask

    task automatic expect_write(input string tag, input int a, input int d);
        chk(tag, {g_wr, g_ack}, 2'b11);
        chk(tag, g_addr, a);
        chk(tag, g_data, d);
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", {wr_en, vfy, ack}, 0);
        send(8'hE4, 8'h05, 8'h00, ME);
        chk("R1 cleared location verifies 00", g_vfy, 1);
    endtask

    task automatic t_write_byte();
        send(8'hEC, 8'h03, 8'hA5, ME);
        expect_quiet("R2 first write packet silent");
        send(8'hEC, 8'h03, 8'hA5, ME);
        expect_write("R2 second identical commits", 3, 8'hA5);
        send(8'hE4, 8'h03, 8'hA5, ME);
        chk("R5 verify match", g_vfy, 1);
        send(8'hE4, 8'h03, 8'hA4, ME);
        chk("R5 verify mismatch", g_vfy, 0);
    endtask

    task automatic t_cancel();
        send(8'hEC, 8'h04, 8'h3C, ME);
        send(8'h00, 8'h00, 8'h00, BC);
        expect_quiet("R11 broadcast silent");
        send(8'hEC, 8'h04, 8'h3C, ME);
        expect_quiet("R3 broadcast cancelled pending");
        send(8'hEC, 8'h04, 8'h3C, ME);
        expect_write("R3 new pair commits", 4, 8'h3C);
        send(8'hEC, 8'h06, 8'h11, ME);
        send(8'hE4, 8'h06, 8'h00, ME);
        chk("R3 intervening verify result", g_vfy, 1);
        send(8'hEC, 8'h06, 8'h11, ME);
        expect_quiet("R3 verify cancelled pending");
        send(8'hEC, 8'h09, 8'h55, BC);
        send(8'hEC, 8'h09, 8'h55, BC);
        expect_quiet("R11 broadcast write pair ignored");
    endtask

    task automatic t_other();
        send(8'hEC, 8'h07, 8'h5A, ME);
        send(8'hE4, 8'h07, 8'h00, NONE);
        expect_quiet("R4 foreign packet silent");
        send(8'hEC, 8'h07, 8'h5A, ME);
        expect_write("R4 pending survived foreign packet", 7, 8'h5A);
    endtask

    task automatic t_bits();
        send(8'hE8, 8'h03, 8'hFE, ME);
        expect_quiet("R6 first bit write silent");
        send(8'hE8, 8'h03, 8'hFE, ME);
        expect_write("R6 set bit 6", 3, 8'hE5);
        send(8'hE8, 8'h03, 8'hEE, ME);
        chk("R6 verify bit 6 is 1", g_vfy, 1);
        send(8'hE8, 8'h03, 8'hE6, ME);
        chk("R6 verify bit 6 is 0 fails", g_vfy, 0);
        send(8'hE8, 8'h03, 8'hF0, ME);
        send(8'hE8, 8'h03, 8'hF0, ME);
        expect_write("R6 clear bit 0", 3, 8'hE4);
    endtask

    task automatic t_reserved();
        send(8'hE0, 8'h03, 8'hE4, ME);
        send(8'hE0, 8'h03, 8'hE4, ME);
        expect_quiet("R7 code 00 ignored");
        send(8'hE8, 8'h03, 8'h7E, ME);
        send(8'hE8, 8'h03, 8'h7E, ME);
        expect_quiet("R7 bad bit prefix ignored");
        send(8'hF5, 8'h01, 8'h00, ME);
        expect_quiet("R9 reserved short code ignored");
    endtask

    task automatic t_consist();
        send(8'hEC, 8'h08, 8'h77, CO);
        send(8'hEC, 8'h08, 8'h77, CO);
        expect_quiet("R8 long write at consist ignored");
        send(8'hE4, 8'h03, 8'hE4, CO);
        expect_quiet("R8 long verify at consist ignored");
        send(8'hF2, 8'h10, 8'h00, CO);
        expect_write("R9 short form at consist", 22, 8'h10);
    endtask

    task automatic t_short();
        send(8'hF2, 8'h33, 8'h00, ME);
        expect_write("R9 accel single packet", 22, 8'h33);
        send(8'hF3, 8'h44, 8'h00, ME);
        expect_write("R9 decel single packet", 23, 8'h44);
        send(8'hE4, 8'h17, 8'h44, ME);
        chk("R9 decel stored", g_vfy, 1);
    endtask

    task automatic t_range();
        send(8'hEC, 8'h28, 8'h99, ME);
        send(8'hEC, 8'h28, 8'h99, ME);
        chk("R10 out of range ack only", {g_wr, g_ack}, 2'b01);
        send(8'hE4, 8'h28, 8'h00, ME);
        chk("R10 out of range reads 00", g_vfy, 1);
        send(8'hE7, 8'hFF, 8'h00, ME);
        chk("R10 top address reads 00", g_vfy, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_byte();
        t_cancel();
        t_other();
        t_bits();
        t_reserved();
        t_consist();
        t_short();
        t_range();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule